// File: doc/BRIEF.md
# Cascaded Boxcar Averaging and Decimating Filter

This block turns a stream of signed 16-bit sensor readings into lower-rate, smoothed results. A strobe generator counts pulses of a 32768 Hz reference enable and fires one sample strobe every period+1 reference pulses. On each strobe the block captures `smp_data` and passes it through a triangular-weighted FIR, built as two identical running averages of 2^B taps each, so the combined response spans 2·2^B−1 taps. A final accumulate-and-dump stage sums 2^D consecutive results of the second average, divides by 2^D with an arithmetic shift, and emits one result per 2^D strobes.

Three registers, written through a plain write port, hold the strobe period, the tap exponent B and the decimation exponent D. Any write to B or D empties all tap histories, accumulators and the decimation count, so the next results are built only from samples taken after the write; history slots not yet refilled count as zero. The result stream is a one-cycle `out_valid` pulse with `out_data`. There is no back-pressure: the consumer must take every pulse in the cycle it appears, and pulses are always at least 16 clocks apart.

Top module: `avgdec_chain`

## Requirements
- R1: After reset `out_valid` and `smp_tick` are low, the period register holds 31, and B and D hold 0.
- R2: With `ref_tick` high, `smp_tick` pulses for one cycle every period+1 reference pulses; the period register is at `cfg_addr` 0, all 16 bits of `cfg_wdata`. With the reset period this gives 32768/32 = 1024 strobes per second.
- R3: A period value below 15 behaves as 15, so strobes are never closer than 16 reference pulses.
- R4: Each of the two averaging stages outputs floor(sum of its last 2^B inputs / 2^B); B is `cfg_wdata[2:0]` at `cfg_addr` 1 and bits 15:3 are ignored.
- R5: The decimating stage outputs floor(sum of 2^D consecutive second-stage results / 2^D), one result per 2^D strobes; D is `cfg_wdata[4:0]` at `cfg_addr` 2 and bits 15:5 are ignored.
- R6: A D value above `DEC_EXP_MAX` (default 16) acts as `DEC_EXP_MAX`.
- R7: With B = 0 and D = 0 every captured sample appears unchanged at `out_data`.
- R8: A write to B or D clears both tap histories, both running sums, the decimation sum and its count; later results treat pre-write samples as zero.
- R9: `out_valid` is a single-cycle pulse, high exactly three clocks after the `smp_tick` cycle whose sample completes that result.
- R10: Sums never overflow: a constant full-scale input (−32768 or +32767) yields exactly that value once the windows are filled, for any B and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per 32768 Hz reference pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 period, 1 B, 2 D |
| cfg_wdata | input | 16 | Register write data |
| smp_data | input | 16 | Signed sensor reading, captured in the `smp_tick` cycle |
| smp_tick | output | 1 | Sample strobe |
| out_valid | output | 1 | Result pulse |
| out_data | output | 16 | Signed averaged, decimated result |

## Verification
Each sample is captured at the clock edge ending its `smp_tick` cycle, the first average registers one edge later, the second one edge after that, and the decimator a third, so a result is due in the third cycle after the strobe that completes it. The bench keeps a reference model that recomputes each window by direct summation; when a strobe completes a decimation group it stores the value together with that due cycle, and at every falling edge it requires `out_valid` exactly in the due cycles, with the stored value, and low in all others. Register writes are made with the reference pulses held off and the pipeline drained, so the clearing edge is unambiguous for both the model and the design.

// File: rtl/avgdec_pkg.sv
package avgdec_pkg;
  localparam int SAMPLE_W  = 16;  // signed sample width
  localparam int GUARD_W   = 16;  // extra accumulator headroom
  localparam int TAP_EXP_W = 3;   // width of the B field
  localparam int DEC_EXP_W = 5;   // width of the D field
  localparam int PERIOD_W  = 16;  // width of the period register
  localparam int PERIOD_MIN = 15;
  localparam int PERIOD_RST = 31;

  typedef enum logic [1:0] {
    CFG_PERIOD = 2'd0,
    CFG_TAPS   = 2'd1,
    CFG_DECIM  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/avgdec_strobe.sv
module avgdec_strobe #(
  parameter int PW     = 16,
  parameter int PMIN   = 15,
  parameter int PRESET = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] period_eff;

  // Periods shorter than the minimum are stretched to it
  assign period_eff = (period < PW'(PMIN)) ? PW'(PMIN) : period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (ref_tick) begin
      if (cnt >= period_eff) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // Strobes can never be adjacent: minimum spacing is PMIN+1 reference pulses
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("strobe repeated"); // R3
endmodule

// File: rtl/avgdec_boxcar.sv
module avgdec_boxcar #(
  parameter int W     = 16,
  parameter int GUARD = 16,
  parameter int EXP_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [EXP_W-1:0]    exp_sel,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  localparam int PTR_W = (1 << EXP_W) - 1;
  localparam int DEPTH = 1 << PTR_W;
  localparam int ACC_W = W + GUARD;

  logic signed [W-1:0]     hist [DEPTH];
  logic [PTR_W-1:0]        ptr;
  logic [PTR_W-1:0]        mask;
  logic signed [ACC_W-1:0] sum, sum_nx, add_ext, drop_ext;
  logic signed [W-1:0]     oldest;

  assign mask     = PTR_W'((32'd1 << exp_sel) - 32'd1);
  assign oldest   = hist[ptr];
  assign add_ext  = {{GUARD{in_data[W-1]}}, in_data};
  assign drop_ext = {{GUARD{oldest[W-1]}}, oldest};
  // Running window sum: newest sample in, sample 2^B strobes old out
  assign sum_nx   = sum + add_ext - drop_ext;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sum       <= '0;
      ptr       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum       <= sum_nx;
        hist[ptr] <= in_data;
        ptr       <= (ptr + 1'b1) & mask;
        out_data  <= W'(sum_nx >>> exp_sel);
      end
    end
  end

  AST_BOX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> out_valid) else $error("stage dropped a sample"); // R9
  AST_BOX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || clr) |=> !out_valid) else $error("stage spurious output"); // R9
  AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr & ~mask) == '0) else $error("pointer outside window"); // R4
endmodule

// File: rtl/avgdec_decim.sv
module avgdec_decim #(
  parameter int W       = 16,
  parameter int GUARD   = 16,
  parameter int EXP_W   = 5,
  parameter int EXP_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [EXP_W-1:0]    exp_sel,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  localparam int ACC_W = W + GUARD;
  localparam int CW    = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [EXP_W-1:0]        d_eff;
  logic [CW-1:0]           cnt, lim;
  logic signed [ACC_W-1:0] acc, acc_nx;

  assign d_eff  = (exp_sel > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_sel;
  assign lim    = CW'((33'd1 << d_eff) - 33'd1);
  assign acc_nx = acc + {{GUARD{in_data[W-1]}}, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (cnt == lim) begin
          out_data  <= W'(acc_nx >>> d_eff);
          out_valid <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_nx;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DEC_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim) else $error("decimation count past group"); // R6
  AST_DEC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt == '0)) else $error("group not restarted"); // R5
endmodule

// File: rtl/avgdec_chain.sv
module avgdec_chain
  import avgdec_pkg::*;
#(
  parameter int DEC_EXP_MAX = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_tick,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_addr,
  input  logic [15:0]                cfg_wdata,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  output logic                       smp_tick,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_data
);
  localparam int NSTAGE = 2;

  logic [PERIOD_W-1:0]  period_q;
  logic [TAP_EXP_W-1:0] taps_q;
  logic [DEC_EXP_W-1:0] decim_q;
  logic                 clr;

  assign clr = cfg_we && (cfg_addr == CFG_TAPS || cfg_addr == CFG_DECIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= PERIOD_W'(PERIOD_RST);
      taps_q   <= '0;
      decim_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_PERIOD: period_q <= cfg_wdata[PERIOD_W-1:0];
        CFG_TAPS:   taps_q   <= cfg_wdata[TAP_EXP_W-1:0];
        CFG_DECIM:  decim_q  <= cfg_wdata[DEC_EXP_W-1:0];
        default: ;
      endcase
    end
  end

  avgdec_strobe #(.PW(PERIOD_W), .PMIN(PERIOD_MIN), .PRESET(PERIOD_RST)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .period(period_q), .tick(smp_tick)
  );

  logic                       st_v [NSTAGE+1];
  logic signed [SAMPLE_W-1:0] st_d [NSTAGE+1];

  assign st_v[0] = smp_tick;
  assign st_d[0] = smp_data;

  // Two identical running averages form the triangular-weighted FIR
  for (genvar s = 0; s < NSTAGE; s++) begin : g_box
    avgdec_boxcar #(.W(SAMPLE_W), .GUARD(GUARD_W), .EXP_W(TAP_EXP_W)) u_box (
      .clk(clk), .rst_n(rst_n), .clr(clr), .exp_sel(taps_q),
      .in_valid(st_v[s]), .in_data(st_d[s]),
      .out_valid(st_v[s+1]), .out_data(st_d[s+1])
    );
  end

  avgdec_decim #(.W(SAMPLE_W), .GUARD(GUARD_W), .EXP_W(DEC_EXP_W), .EXP_MAX(DEC_EXP_MAX)) u_decim (
    .clk(clk), .rst_n(rst_n), .clr(clr), .exp_sel(decim_q),
    .in_valid(st_v[NSTAGE]), .in_data(st_d[NSTAGE]),
    .out_valid(out_valid), .out_data(out_data)
  );

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_tick, 3)) else $error("result not three cycles after strobe"); // R9
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid) else $error("result pulse too long"); // R9
endmodule

// File: tb/avgdec_chain_tb.sv
`timescale 1ns/1ps
module avgdec_chain_tb;
  localparam int DMAX = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n, ref_tick, cfg_we;
  logic [1:0]         cfg_addr;
  logic [15:0]        cfg_wdata;
  logic signed [15:0] smp_data;
  logic               smp_tick, out_valid;
  logic signed [15:0] out_data;

  avgdec_chain #(.DEC_EXP_MAX(DMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .smp_data(smp_data),
    .smp_tick(smp_tick), .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_ticks = 0, last_tick = 0, gap_last = 0, n_out = 0;
  longint hx [128];
  longint hs [128];
  longint dacc;
  int dcnt, mb, md;
  longint q_val [$];
  int q_due [$];
  longint first_out, last_out;
  bit first_seen;
  int mode;
  logic [15:0] lfsr = 16'hACE1;
  int idx = 0;
  logic signed [15:0] cval = 16'sd0;
  string cur_req = "R7";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 128; i++) begin hx[i] = 0; hs[i] = 0; end
    dacc = 0; dcnt = 0; first_seen = 0;
  endtask

  // Reference model: direct window sums, floor division by shifting
  task automatic model_step(input longint x);
    longint s;
    longint s1;
    longint s2;
    int deff;
    for (int i = 127; i > 0; i--) hx[i] = hx[i-1];
    hx[0] = x;
    s = 0;
    for (int i = 0; i < (1 << mb); i++) s += hx[i];
    s1 = s >>> mb;
    for (int i = 127; i > 0; i--) hs[i] = hs[i-1];
    hs[0] = s1;
    s = 0;
    for (int i = 0; i < (1 << mb); i++) s += hs[i];
    s2 = s >>> mb;
    deff = (md > DMAX) ? DMAX : md;
    dacc += s2;
    dcnt++;
    if (dcnt == (1 << deff)) begin
      q_val.push_back(dacc >>> deff);
      q_due.push_back(cyc + 3);
      dacc = 0;
      dcnt = 0;
    end
  endtask

  // Monitor and stimulus source, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(out_valid === 1'b1, "R9", longint'(out_valid), 1);
        chk(longint'(out_data) == q_val[0], cur_req, longint'(out_data), q_val[0]);
        if (out_valid) begin
          n_out++;
          last_out = out_data;
          if (!first_seen) begin first_out = out_data; first_seen = 1; end
        end
        void'(q_val.pop_front());
        void'(q_due.pop_front());
      end else if (out_valid) begin
        chk(1'b0, "R9", 1, 0);
      end
    end
    idx++;
    case (mode)
      0: smp_data = 16'(idx * 37 - 500);
      1: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        smp_data = lfsr;
      end
      default: smp_data = cval;
    endcase
    if (rst_n && smp_tick) begin
      n_ticks++;
      gap_last = cyc - last_tick;
      last_tick = cyc;
      model_step(longint'(smp_data));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 2'd1) begin mb = int'(d[2:0]); model_clear(); end
    if (a == 2'd2) begin md = int'(d[4:0]); model_clear(); end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    int target;
    target = n_ticks + n;
    ref_tick = 1'b1;
    while (n_ticks < target) @(negedge clk);
    ref_tick = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(smp_tick === 1'b0, "R1", longint'(smp_tick), 0);
  endtask

  task automatic t_default_rate();
    int n0;
    cur_req = "R7";
    mode = 0;
    n0 = n_out;
    run(4);
    chk(gap_last == 32, "R2", gap_last, 32);
    run(36);
    chk(n_out - n0 == 40, "R7", n_out - n0, 40);
  endtask

  task automatic t_period();
    wr(2'd0, 16'd20);
    run(4);
    chk(gap_last == 21, "R2", gap_last, 21);
    wr(2'd0, 16'd5);
    run(4);
    chk(gap_last == 16, "R3", gap_last, 16);
    wr(2'd0, 16'd15);
  endtask

  task automatic t_bartlett();
    int n0;
    cur_req = "R4";
    mode = 2; cval = 16'sd100;
    wr(2'd1, 16'hFFFA);  // B = 2, upper bits ignored
    n0 = n_out;
    run(30);
    chk(n_out - n0 == 30, "R4", n_out - n0, 30);
    chk(first_out == 6, "R8", first_out, 6);
    chk(last_out == 100, "R4", last_out, 100);
    cur_req = "R8";
    wr(2'd1, 16'd2);     // rewrite clears the filled history
    run(1);
    chk(first_out == 6, "R8", first_out, 6);
    cur_req = "R4";
    mode = 1;
    run(40);
  endtask

  task automatic t_decim();
    int n0;
    cur_req = "R5";
    mode = 1;
    wr(2'd1, 16'd1);
    wr(2'd2, 16'hFFE3);  // D = 3, upper bits ignored
    n0 = n_out;
    run(80);
    chk(n_out - n0 == 10, "R5", n_out - n0, 10);
  endtask

  task automatic t_clamp();
    int n0;
    cur_req = "R6";
    mode = 0;
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd31);    // acts as DMAX = 6
    n0 = n_out;
    run(200);
    chk(n_out - n0 == 3, "R6", n_out - n0, 3);
  endtask

  task automatic t_fullscale();
    int n0;
    cur_req = "R10";
    mode = 2; cval = -16'sd32768;
    wr(2'd1, 16'd7);
    wr(2'd2, 16'd2);
    n0 = n_out;
    run(300);
    chk(n_out - n0 == 75, "R10", n_out - n0, 75);
    chk(last_out == -32768, "R10", last_out, -32768);
    cval = 16'sd32767;
    wr(2'd2, 16'd5);
    run(320);
    chk(last_out == 32767, "R10", last_out, 32767);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 16'd0;
    smp_data = 16'sd0; mode = 0; mb = 0; md = 0;
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_rate();
    t_period();
    t_bartlett();
    t_decim();
    t_clamp();
    t_fullscale();
    chk(q_due.size() == 0, "R9", q_due.size(), 0);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
  end
endmodule